// File: doc/BRIEF.md
# Three-Channel Interval Timer

This block holds three independent 16-bit down counters behind a byte-wide register interface. Ports 0, 1 and 2 reach the counters' data. Port 3 takes control words, each of which points at one counter and sets how that counter's bytes are accessed and how it counts. Every counter has its own count-enable strobe, which marks one count step, a gate that pauses it, and a single output line.

Software programs a counter by writing a control word and then the initial count. A latch command takes a snapshot of a counter that keeps running, so that a two-byte read returns one consistent value. Three counting behaviours are fully implemented: a one-time terminal-count flag, a rate generator that emits one low step per period, and a square wave. The other mode codes are accepted, but only as a free-running stub.

Top module: `tri_interval_timer`

## Requirements
- R1: After a synchronous active-low reset all three outputs are low, no counter runs, and a read of any data port returns 0x00.
- R2: Writes to port 3 are control words. Bits 7:6 pick the counter (00, 01, 10). The value 11 is ignored and leaves every counter and output unchanged.
- R3: Control bits 5:4 set byte access. 01 means low byte only, and the high byte reads and loads as zero. 10 means high byte only, and the low byte loads as zero. 11 means low byte first, then high byte, for both writes and reads. A new control word restarts that byte order.
- R4: Access code 00 latches the selected counter. Data-port reads then return the snapshot while counting goes on. The snapshot is released once a full read completes (one byte, or both bytes in two-byte access). A second latch command issued before that read has no effect.
- R5: Mode code 0 (bits 3:1 = 000) drives the output low on the control word and again on the count write. The output goes high after N count steps and stays high.
- R6: Mode code 2 keeps the output high and drives it low for one count step in every N steps, reloading N automatically.
- R7: Mode code 3 produces a square wave that is high for ceil(N/2) steps and low for floor(N/2) steps, reloading automatically.
- R8: While a counter's gate is low, its count and its output hold.
- R9: A loaded count of 0 acts as 65536 count steps.
- R10: Mode codes 6 and 7 behave as 2 and 3. Codes 1, 4 and 5 are a stub: the output is high and the count decrements freely. Bit 0 (decimal counting) is accepted, but counting stays binary.
- R11: A counter changes only on clock edges where its count-enable bit is high. A count write takes effect at once, with no count step on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read commit; advances read byte order and releases latches |
| addr | input | 2 | Port select: 0..2 counter data, 3 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed counter, combinational on addr |
| cnt_en | input | 3 | Per-counter count-step enable |
| gate | input | 3 | Per-counter gate; low pauses counting |
| out | output | 3 | Per-counter output |

## Verification
Two cases are hard to reach from the ports. One is a latched snapshot that has to survive a running count, a second latch command and a partial read. The other is the two-byte order being reset by a control word that arrives between the low and high byte. The stimulus reaches both by interleaving latch commands, count bursts and single-byte reads on one counter, and by writing a lone low byte, then rewriting the control word, then loading a short count. A wrong byte order would give a very different period, which the output then exposes. The 65536-step case for a zero count is driven with one long burst of count steps.

// File: rtl/tmr_pkg.sv
// Shared constants and the control-word layout for the interval timer.
// Assumes a counter is exactly two bytes wide.
package tmr_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;

    // byte-access codes (control bits 5:4)
    localparam logic [1:0] ACC_LATCH = 2'b00;
    localparam logic [1:0] ACC_LO    = 2'b01;
    localparam logic [1:0] ACC_HI    = 2'b10;
    localparam logic [1:0] ACC_BOTH  = 2'b11;

    // normalised counting modes (control bits 3:1)
    localparam logic [2:0] MD_TERM = 3'd0;
    localparam logic [2:0] MD_RATE = 3'd2;
    localparam logic [2:0] MD_SQR  = 3'd3;

    localparam logic [1:0] PORT_CTL = 2'd3;

    // control word without bit 0 (decimal select, not implemented)
    typedef struct packed {
        logic [1:0] sel;
        logic [1:0] acc;
        logic [2:0] mode;
    } cw_t;
endpackage

// File: rtl/tmr_cw_decode.sv
// Control-word and data-port decoder.
// Turns a bus write into per-counter strobes: control load, latch command,
// data write. Folds mode codes 6/7 onto 2/3. Selector 11 hits no counter.
module tmr_cw_decode
    import tmr_pkg::*;
#(
    parameter int N_CH = 3
) (
    input  logic            wr_en,
    input  logic [1:0]      addr,
    input  logic [7:1]      cw_bits,
    output logic [N_CH-1:0] cw_load,
    output logic [N_CH-1:0] latch_cmd,
    output logic [N_CH-1:0] data_wr,
    output logic [1:0]      cw_acc,
    output logic [2:0]      cw_mode
);
    cw_t cw;
    logic is_ctl;

    assign cw     = cw_t'(cw_bits);
    assign is_ctl = wr_en && (addr == PORT_CTL);
    assign cw_acc = cw.acc;

    // fold the duplicate mode codes onto their base modes
    always_comb begin
        cw_mode = cw.mode[1] ? {1'b0, cw.mode[1:0]} : cw.mode;
    end

    for (genvar i = 0; i < N_CH; i++) begin : g_strobe
        // per-counter strobes from the shared ports
        always_comb begin
            cw_load[i]   = is_ctl && (cw.sel == 2'(i)) && (cw.acc != ACC_LATCH);
            latch_cmd[i] = is_ctl && (cw.sel == 2'(i)) && (cw.acc == ACC_LATCH);
            data_wr[i]   = wr_en && (addr == 2'(i));
        end
    end
endmodule

// File: rtl/tmr_chan.sv
// One 16-bit down counter with its byte-access state, snapshot latch and
// output waveform logic. Assumes at most one bus operation per cycle.
// A count write loads immediately; count steps need tick && gate.
module tmr_chan
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cw_load,
    input  logic [1:0]        cw_acc,
    input  logic [2:0]        cw_mode,
    input  logic              latch_cmd,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              tick,
    input  logic              gate,
    output logic [BYTE_W-1:0] rbyte,
    output logic              out_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [1:0]       rw_q;
    logic [2:0]       mode_q;
    logic [CNT_W-1:0] cnt_q, reload_q, latch_q;
    logic             latched_q, wtog_q, rtog_q, armed_q, out_q;
    logic [CNT_W-1:0] load_val, cnt_nx, cnt_dec, src;
    logic             out_nx, wr_done;

    // count value with zero standing for 2**CNT_W
    function automatic logic [CNT_W:0] span(input logic [CNT_W-1:0] v);
        span = (v == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, v};
    endfunction

    // value a data write produces under the current access pattern
    always_comb begin
        case (rw_q)
            ACC_LO:  load_val = {{BYTE_W{1'b0}}, wdata};
            ACC_HI:  load_val = {wdata, {BYTE_W{1'b0}}};
            default: load_val = wtog_q ? {wdata, reload_q[BYTE_W-1:0]}
                                       : {reload_q[CNT_W-1:BYTE_W], wdata};
        endcase
    end

    assign wr_done = data_wr && ((rw_q != ACC_BOTH) || wtog_q);

    // next count and output for one count step
    always_comb begin
        cnt_dec = cnt_q - ONE;
        case (mode_q)
            MD_TERM: begin
                cnt_nx = cnt_dec;
                out_nx = out_q || (cnt_q == ONE);
            end
            MD_RATE: begin
                cnt_nx = (cnt_q == ONE) ? reload_q : cnt_dec;
                out_nx = (cnt_q != ONE);
            end
            MD_SQR: begin
                cnt_nx = (cnt_q == ONE) ? reload_q : cnt_dec;
                out_nx = span(cnt_nx) > (span(reload_q) >> 1);
            end
            default: begin
                cnt_nx = cnt_dec;
                out_nx = 1'b1;
            end
        endcase
    end

    // programming, loading, counting, latching and read sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rw_q      <= ACC_LO;
            mode_q    <= MD_TERM;
            cnt_q     <= '0;
            reload_q  <= '0;
            latch_q   <= '0;
            latched_q <= 1'b0;
            wtog_q    <= 1'b0;
            rtog_q    <= 1'b0;
            armed_q   <= 1'b0;
            out_q     <= 1'b0;
        end else if (cw_load) begin
            rw_q      <= cw_acc;
            mode_q    <= cw_mode;
            wtog_q    <= 1'b0;
            rtog_q    <= 1'b0;
            latched_q <= 1'b0;
            armed_q   <= 1'b0;
            out_q     <= (cw_mode != MD_TERM);
        end else begin
            if (data_wr) begin
                reload_q <= load_val;
                if (rw_q == ACC_BOTH) wtog_q <= ~wtog_q;
                if (wr_done) begin
                    cnt_q   <= load_val;
                    armed_q <= 1'b1;
                    out_q   <= (mode_q != MD_TERM);
                end
            end else if (armed_q && tick && gate) begin
                cnt_q <= cnt_nx;
                out_q <= out_nx;
            end
            if (latch_cmd && !latched_q) begin
                latch_q   <= cnt_q;
                latched_q <= 1'b1;
            end
            if (data_rd) begin
                if (rw_q == ACC_BOTH) rtog_q <= ~rtog_q;
                if (latched_q && ((rw_q != ACC_BOTH) || rtog_q)) latched_q <= 1'b0;
            end
        end
    end

    // byte presented on a data-port read
    always_comb begin
        src   = latched_q ? latch_q : cnt_q;
        rbyte = ((rw_q == ACC_HI) || ((rw_q == ACC_BOTH) && rtog_q))
                ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
    end

    assign out_o = out_q;

    // R5: once high in terminal-count mode the output stays high
    a_r5_term_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_TERM) && out_q && !cw_load && !data_wr |=> out_q);

    // R6: a low phase of the rate generator lasts one count step
    a_r6_single_low: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && (mode_q == MD_RATE) && !out_q && tick && gate &&
        !cw_load && !data_wr && (reload_q != ONE) |=> out_q);

    // R4: a held snapshot neither changes nor drops without a read
    a_r4_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        latched_q && !cw_load && !data_rd |=> latched_q && $stable(latch_q));

    // R8: gate low freezes count and output
    a_r8_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && !gate && !cw_load && !data_wr |=> $stable(cnt_q) && $stable(out_q));

    // R11: no count enable, no bus write, no change of count
    a_r11_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !cw_load && !data_wr |=> $stable(cnt_q));
endmodule

// File: rtl/tri_interval_timer.sv
// Three-channel interval timer top: a shared decoder feeding three counters,
// plus the read-data mux. Assumes N_CH <= 3 (two-bit selector, port 3 is control).
module tri_interval_timer
    import tmr_pkg::*;
#(
    parameter int N_CH = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [1:0]      addr,
    input  logic [7:0]      wdata,
    output logic [7:0]      rdata,
    input  logic [N_CH-1:0] cnt_en,
    input  logic [N_CH-1:0] gate,
    output logic [N_CH-1:0] out
);
    logic [N_CH-1:0] cw_load, latch_cmd, data_wr, data_rd;
    logic [1:0]      cw_acc;
    logic [2:0]      cw_mode;
    logic [7:0]      rbyte [N_CH];

    tmr_cw_decode #(.N_CH(N_CH)) u_dec (
        .wr_en     (wr_en),
        .addr      (addr),
        .cw_bits   (wdata[7:1]),
        .cw_load   (cw_load),
        .latch_cmd (latch_cmd),
        .data_wr   (data_wr),
        .cw_acc    (cw_acc),
        .cw_mode   (cw_mode)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        // read commit strobe for this counter
        assign data_rd[i] = rd_en && (addr == 2'(i));

        tmr_chan u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .cw_load   (cw_load[i]),
            .cw_acc    (cw_acc),
            .cw_mode   (cw_mode),
            .latch_cmd (latch_cmd[i]),
            .data_wr   (data_wr[i]),
            .data_rd   (data_rd[i]),
            .wdata     (wdata),
            .tick      (cnt_en[i]),
            .gate      (gate[i]),
            .rbyte     (rbyte[i]),
            .out_o     (out[i])
        );
    end

    // select the addressed counter's byte; control port reads as zero
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_CH; i++)
            if (addr == 2'(i)) rdata = rbyte[i];
    end

    // R2: one control write reaches at most one counter
    a_r2_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cw_load | latch_cmd));

    // R2: selector 11 reaches no counter
    a_r2_sel3_void: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (addr == 2'd3) && (wdata[7:6] == 2'b11) |-> ((cw_load | latch_cmd) == '0));
endmodule

// File: tb/tri_interval_timer_test.sv
module tri_interval_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [2:0] cnt_en = 3'b000;
    logic [2:0] gate = 3'b111;
    logic [2:0] out;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;  // 250 MHz

    tri_interval_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cnt_en(cnt_en), .gate(gate), .out(out)
    );

    localparam logic [3:0] OP_WR = 4'd0, OP_RD = 4'd1, OP_TO = 4'd2, OP_GT = 4'd3;
    // entry: {op, channel/port, step count, data or expected, requirement}
    localparam int NV = 62;
    localparam logic [39:0] VEC [NV] = '{
        {OP_WR, 4'd3, 16'd0,   8'h30, 8'd5},  // ch0 both bytes, mode 0  R5
        {OP_TO, 4'd0, 16'd0,   8'h00, 8'd5},
        {OP_WR, 4'd0, 16'd0,   8'h05, 8'd3},
        {OP_WR, 4'd0, 16'd0,   8'h00, 8'd3},
        {OP_TO, 4'd0, 16'd4,   8'h00, 8'd5},
        {OP_TO, 4'd0, 16'd1,   8'h01, 8'd5},
        {OP_TO, 4'd0, 16'd3,   8'h01, 8'd5},
        {OP_RD, 4'd0, 16'd0,   8'hFD, 8'd3},  // R3 low byte first
        {OP_RD, 4'd0, 16'd0,   8'hFF, 8'd3},
        {OP_WR, 4'd3, 16'd0,   8'h00, 8'd4},  // latch ch0  R4
        {OP_TO, 4'd0, 16'd2,   8'h01, 8'd5},
        {OP_RD, 4'd0, 16'd0,   8'hFD, 8'd4},
        {OP_RD, 4'd0, 16'd0,   8'hFF, 8'd4},
        {OP_RD, 4'd0, 16'd0,   8'hFB, 8'd4},  // released: live count
        {OP_RD, 4'd0, 16'd0,   8'hFF, 8'd4},
        {OP_WR, 4'd3, 16'd0,   8'h00, 8'd4},
        {OP_TO, 4'd0, 16'd1,   8'h01, 8'd5},
        {OP_WR, 4'd3, 16'd0,   8'h00, 8'd4},  // second latch ignored
        {OP_TO, 4'd0, 16'd1,   8'h01, 8'd5},
        {OP_RD, 4'd0, 16'd0,   8'hFB, 8'd4},
        {OP_RD, 4'd0, 16'd0,   8'hFF, 8'd4},
        {OP_RD, 4'd0, 16'd0,   8'hF9, 8'd4},
        {OP_RD, 4'd0, 16'd0,   8'hFF, 8'd4},
        {OP_WR, 4'd3, 16'd0,   8'h54, 8'd6},  // ch1 low only, mode 2  R6
        {OP_WR, 4'd1, 16'd0,   8'h04, 8'd3},
        {OP_TO, 4'd1, 16'd0,   8'h01, 8'd6},
        {OP_TO, 4'd1, 16'd3,   8'h01, 8'd6},
        {OP_TO, 4'd1, 16'd1,   8'h00, 8'd6},
        {OP_TO, 4'd1, 16'd1,   8'h01, 8'd6},
        {OP_TO, 4'd1, 16'd2,   8'h01, 8'd6},
        {OP_TO, 4'd1, 16'd1,   8'h00, 8'd6},
        {OP_RD, 4'd1, 16'd0,   8'h04, 8'd3},
        {OP_WR, 4'd3, 16'd0,   8'hA6, 8'd7},  // ch2 high only, mode 3  R7
        {OP_WR, 4'd2, 16'd0,   8'h01, 8'd3},
        {OP_TO, 4'd2, 16'd127, 8'h01, 8'd7},
        {OP_TO, 4'd2, 16'd1,   8'h00, 8'd7},
        {OP_TO, 4'd2, 16'd127, 8'h00, 8'd7},
        {OP_TO, 4'd2, 16'd1,   8'h01, 8'd7},
        {OP_RD, 4'd2, 16'd0,   8'h01, 8'd3},
        {OP_WR, 4'd3, 16'd0,   8'h76, 8'd7},  // ch1 both, mode 3, N=5
        {OP_WR, 4'd1, 16'd0,   8'h05, 8'd7},
        {OP_WR, 4'd1, 16'd0,   8'h00, 8'd7},
        {OP_TO, 4'd1, 16'd2,   8'h01, 8'd7},
        {OP_TO, 4'd1, 16'd1,   8'h00, 8'd7},
        {OP_TO, 4'd1, 16'd1,   8'h00, 8'd7},
        {OP_TO, 4'd1, 16'd1,   8'h01, 8'd7},
        {OP_GT, 4'd0, 16'd0,   8'h05, 8'd8},  // ch1 gate low  R8
        {OP_TO, 4'd1, 16'd2,   8'h01, 8'd8},
        {OP_RD, 4'd1, 16'd0,   8'h05, 8'd8},
        {OP_RD, 4'd1, 16'd0,   8'h00, 8'd8},
        {OP_GT, 4'd0, 16'd0,   8'h07, 8'd8},
        {OP_TO, 4'd1, 16'd2,   8'h01, 8'd8},
        {OP_TO, 4'd1, 16'd1,   8'h00, 8'd8},
        {OP_WR, 4'd3, 16'd0,   8'h30, 8'd3},  // byte order restart  R3
        {OP_WR, 4'd0, 16'd0,   8'h34, 8'd3},
        {OP_WR, 4'd3, 16'd0,   8'h30, 8'd3},
        {OP_WR, 4'd0, 16'd0,   8'h03, 8'd3},
        {OP_WR, 4'd0, 16'd0,   8'h00, 8'd3},
        {OP_TO, 4'd0, 16'd2,   8'h00, 8'd3},
        {OP_TO, 4'd0, 16'd1,   8'h01, 8'd3},
        {OP_WR, 4'd3, 16'd0,   8'hF0, 8'd2},  // selector 11 ignored  R2
        {OP_TO, 4'd0, 16'd0,   8'h01, 8'd2}
    };

    task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [1:0] a, input logic [7:0] exp, input int req);
        @(negedge clk);
        addr = a;
        #1;
        check(req, rdata, exp);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_ticks(input int n, input logic [2:0] en);
        @(negedge clk);
        if (n > 0) begin
            cnt_en = en;
            repeat (n) @(negedge clk);
            cnt_en = 3'b000;
        end
    endtask

    task automatic chk_out(input int ch, input logic exp, input int req);
        #1;
        check(req, {7'd0, out[ch]}, {7'd0, exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(1, {5'd0, out}, 8'h00);
        for (int p = 0; p < 3; p++) begin
            addr = 2'(p);
            #1;
            check(1, rdata, 8'h00);
        end
        rst_n = 1'b1;
        do_ticks(4, 3'b111);
        check(1, {5'd0, out}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [39:0] v;
            v = VEC[i];
            case (v[39:36])
                OP_WR: do_wr(v[33:32], v[15:8]);
                OP_RD: do_rd(v[33:32], v[15:8], int'(v[7:0]));
                OP_TO: begin
                    do_ticks(int'(v[31:16]), 3'b111);
                    chk_out(int'(v[35:32]), v[8], int'(v[7:0]));
                end
                default: begin
                    @(negedge clk);
                    gate = v[10:8];
                end
            endcase
        end

        // R10: mode code 6 acts as rate generator
        do_wr(2'd3, 8'h1C);
        do_wr(2'd0, 8'h03);
        do_ticks(2, 3'b001); chk_out(0, 1'b1, 10);
        do_ticks(1, 3'b001); chk_out(0, 1'b0, 10);

        // R10: stub mode 1 keeps output high and counts down
        do_wr(2'd3, 8'h92);
        do_wr(2'd2, 8'h10);
        chk_out(2, 1'b1, 10);
        do_ticks(20, 3'b100); chk_out(2, 1'b1, 10);
        do_rd(2'd2, 8'hFC, 10);

        // R10 decimal bit counts binary; R11 idle cycles without enable do nothing
        do_wr(2'd3, 8'h51);
        do_wr(2'd1, 8'h10);
        do_ticks(5, 3'b101);          // only other channels step (R11)
        repeat (5) @(negedge clk);
        do_ticks(15, 3'b010); chk_out(1, 1'b0, 11);
        do_ticks(1, 3'b010);  chk_out(1, 1'b1, 10);

        // R9: zero count means 65536 steps
        do_wr(2'd3, 8'h30);
        do_wr(2'd0, 8'h00);
        do_wr(2'd0, 8'h00);
        do_ticks(65535, 3'b001); chk_out(0, 1'b0, 9);
        do_ticks(1, 3'b001);     chk_out(0, 1'b1, 9);

        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule